// File: doc/BRIEF.md
# System Tick Down-Counter

This block is a periodic tick generator that a processor programs through a small word-wide register window. Software writes a reload value and sets an enable bit. The counter then loads that value and steps down by one on every enabled tick. On the tick that finds it at zero, it raises a count flag, optionally pulses an interrupt request for one cycle, and loads the reload value again. A full period therefore takes reload+1 ticks. A reload value of zero turns the timer into a one-shot: after that single wrap the enable bit clears itself.

The tick comes from one of two places. It can be every core clock cycle, or only the cycles on which an external reference strobe is high; the strobe is a synchronous one-cycle enable. Software can restart the count at any time by writing the current-value register. It can poll for a wrap through the count flag, which is cleared by the read that returns it. A read-only calibration word reports a fixed constant.

Top module: `sys_tick_timer`

## Requirements
- R1: After reset the control, reload and current-value registers read zero, the timer is disabled and the interrupt output is low.
- R2: Word offsets are 0x10 control, 0x14 reload, 0x18 current value and 0x1C calibration. Writes to control store only bits [2:0] (bit 0 enable, bit 1 interrupt enable, bit 2 source, where 1 means core clock). Bit 16 is the count flag, and a control write leaves it unchanged. All other control bits read zero.
- R3: The calibration word always reads 10000, and writes to it have no effect.
- R4: A tick taken while the counter holds zero sets the count flag. If bit 1 is set, the same tick also causes the interrupt output to go high in the following cycle.
- R5: The interrupt output is high for exactly one cycle per wrap.
- R6: When a wrap happens with a reload value of zero, the enable bit clears and counting stops.
- R7: A write of any data to the current-value register loads the reload value into the counter and clears the count flag.
- R8: A read of the control register returns the count flag, and the flag then clears.
- R9: Setting the enable bit loads the reload value. Each tick lowers the count by one, and a wrap loads the reload value again, so wraps come every reload+1 ticks.
- R10: While disabled, the current-value register reads zero, ticks are ignored and no interrupt is raised.
- R11: With bit 2 clear, only cycles with the reference strobe high count as ticks. With bit 2 set, every clock cycle is a tick.
- R12: Changing bit 2 while the timer stays enabled loads the reload value into the counter at once.
- R13: The reload register holds 24 bits; bits [31:24] read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Register write strobe |
| busRdEn | input | 1 | Register read strobe (clears the count flag on a control read) |
| busAddr | input | 8 | Byte offset of the accessed word |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data, valid combinationally while busRdEn is high |
| refTick | input | 1 | External reference tick strobe, one cycle wide |
| tickIrq | output | 1 | One-cycle interrupt request on a wrap |

## Verification
A corrupted counter shows up in the current-value read in the same cycle. A wrong decrement or reload also moves the next interrupt pulse away from its reload+1 tick spacing, and this shows within one period. A mishandled count flag or enable bit shows up at the next control read. The reference-strobe mode lets the bench place every tick by hand, so each read and each pulse can be compared against arithmetic on the tick count.

// File: rtl/sys_tick_pkg.sv
package sys_tick_pkg;
  localparam int unsigned OFS_CTRL   = 'h10;
  localparam int unsigned OFS_RELOAD = 'h14;
  localparam int unsigned OFS_CUR    = 'h18;
  localparam int unsigned OFS_CALIB  = 'h1C;

  localparam int unsigned BIT_EN   = 0;
  localparam int unsigned BIT_INT  = 1;
  localparam int unsigned BIT_SRC  = 2;
  localparam int unsigned BIT_FLAG = 16;

  typedef struct packed {
    logic wrReload;
    logic loadCnt;
    logic decCnt;
  } tickStrobe_t;
endpackage

// File: rtl/sys_tick_dp.sv
module sys_tick_dp
  import sys_tick_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  tickStrobe_t          strobe,
  input  logic [CNT_W-1:0]     wrData,
  output logic [CNT_W-1:0]     cntVal,
  output logic [CNT_W-1:0]     reloadVal,
  output logic                 cntIsZero,
  output logic                 reloadIsZero
);
  logic [CNT_W-1:0] cntReg;
  logic [CNT_W-1:0] reloadReg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reloadReg <= '0;
    end else if (strobe.wrReload) begin
      reloadReg <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cntReg <= '0;
    end else if (strobe.loadCnt) begin
      cntReg <= reloadReg;
    end else if (strobe.decCnt) begin
      cntReg <= cntReg - CNT_W'(1);
    end
  end

  assign cntVal       = cntReg;
  assign reloadVal    = reloadReg;
  assign cntIsZero    = (cntReg == '0);
  assign reloadIsZero = (reloadReg == '0);

  AST_DEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.decCnt && !strobe.loadCnt) |=> (cntVal == $past(cntVal) - CNT_W'(1))); // R9
  AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.loadCnt && !strobe.wrReload) |=> (cntVal == $past(reloadVal))); // R9
endmodule

// File: rtl/sys_tick_ctrl.sv
module sys_tick_ctrl
  import sys_tick_pkg::*;
#(
  parameter int CNT_W  = 24,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CALIB  = 10000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  input  logic              refTick,
  input  logic [CNT_W-1:0]  cntVal,
  input  logic [CNT_W-1:0]  reloadVal,
  input  logic              cntIsZero,
  input  logic              reloadIsZero,
  output tickStrobe_t       strobe,
  output logic              tickIrq
);
  logic ctlEn, ctlInt, ctlSrc, cntFlag;
  logic selCtrl, selReload, selCur, selCalib;
  logic wrCtrl, wrCur, rdCtrl;
  logic tickSrc, tickEn, wrapEvt, enRise, srcFlip;
  logic newEn, newSrc;

  assign selCtrl   = (busAddr == ADDR_W'(OFS_CTRL));
  assign selReload = (busAddr == ADDR_W'(OFS_RELOAD));
  assign selCur    = (busAddr == ADDR_W'(OFS_CUR));
  assign selCalib  = (busAddr == ADDR_W'(OFS_CALIB));

  assign wrCtrl = busWrEn && selCtrl;
  assign wrCur  = busWrEn && selCur;
  assign rdCtrl = busRdEn && selCtrl;

  assign newEn  = busWrData[BIT_EN];
  assign newSrc = busWrData[BIT_SRC];

  // Tick selection: core clock or external strobe; bus writes that touch
  // the count take the cycle instead of a tick.
  assign tickSrc = ctlSrc ? 1'b1 : refTick;
  assign tickEn  = ctlEn && tickSrc && !wrCtrl && !wrCur;
  assign wrapEvt = tickEn && cntIsZero;

  assign enRise  = wrCtrl && newEn && !ctlEn;
  assign srcFlip = wrCtrl && newEn && ctlEn && (newSrc != ctlSrc);

  always_comb begin
    strobe          = '0;
    strobe.wrReload = busWrEn && selReload;
    strobe.loadCnt  = enRise || srcFlip || wrCur || (wrapEvt && !reloadIsZero);
    strobe.decCnt   = tickEn && !cntIsZero;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctlEn  <= 1'b0;
      ctlInt <= 1'b0;
      ctlSrc <= 1'b0;
    end else if (wrCtrl) begin
      ctlEn  <= newEn;
      ctlInt <= busWrData[BIT_INT];
      ctlSrc <= newSrc;
    end else if (wrapEvt && reloadIsZero) begin
      ctlEn  <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cntFlag <= 1'b0;
    end else if (wrapEvt) begin
      cntFlag <= 1'b1;
    end else if (rdCtrl || wrCur) begin
      cntFlag <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tickIrq <= 1'b0;
    end else begin
      tickIrq <= wrapEvt && ctlInt;
    end
  end

  always_comb begin
    busRdData = '0;
    if (busRdEn) begin
      if (selCtrl) begin
        busRdData[BIT_EN]   = ctlEn;
        busRdData[BIT_INT]  = ctlInt;
        busRdData[BIT_SRC]  = ctlSrc;
        busRdData[BIT_FLAG] = cntFlag;
      end else if (selReload) begin
        busRdData = DATA_W'(reloadVal);
      end else if (selCur) begin
        busRdData = ctlEn ? DATA_W'(cntVal) : '0;
      end else if (selCalib) begin
        busRdData = DATA_W'(CALIB);
      end
    end
  end

  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    tickIrq |=> !tickIrq); // R5
  AST_IRQ_WITH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    tickIrq |-> cntFlag); // R4
  AST_IRQ_NEEDS_INT: assert property (@(posedge clk) disable iff (!rst_n)
    tickIrq |-> $past(ctlInt)); // R4
  AST_ZERO_RELOAD_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (wrapEvt && reloadIsZero) |=> !ctlEn); // R6
  AST_CUR_WR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    wrCur |=> !cntFlag); // R7
  AST_CTRL_WR_KEEPS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (wrCtrl && !busRdEn) |=> $stable(cntFlag)); // R2
  AST_OFF_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctlEn) |=> !tickIrq); // R10
endmodule

// File: rtl/sys_tick_timer.sv
module sys_tick_timer
  import sys_tick_pkg::*;
#(
  parameter int CNT_W  = 24,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CALIB  = 10000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  input  logic              refTick,
  output logic              tickIrq
);
  tickStrobe_t      strobe;
  logic [CNT_W-1:0] cntVal;
  logic [CNT_W-1:0] reloadVal;
  logic             cntIsZero;
  logic             reloadIsZero;

  sys_tick_ctrl #(
    .CNT_W (CNT_W),
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .CALIB (CALIB)
  ) uCtrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .busWrEn     (busWrEn),
    .busRdEn     (busRdEn),
    .busAddr     (busAddr),
    .busWrData   (busWrData),
    .busRdData   (busRdData),
    .refTick     (refTick),
    .cntVal      (cntVal),
    .reloadVal   (reloadVal),
    .cntIsZero   (cntIsZero),
    .reloadIsZero(reloadIsZero),
    .strobe      (strobe),
    .tickIrq     (tickIrq)
  );

  sys_tick_dp #(
    .CNT_W(CNT_W)
  ) uDp (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobe      (strobe),
    .wrData      (busWrData[CNT_W-1:0]),
    .cntVal      (cntVal),
    .reloadVal   (reloadVal),
    .cntIsZero   (cntIsZero),
    .reloadIsZero(reloadIsZero)
  );
endmodule

// File: tb/sim_sys_tick_timer.sv
module sim_sys_tick_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        busWrEn = 1'b0;
  logic        busRdEn = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic        refTick = 1'b0;
  logic        tickIrq;

  int nRun = 0;
  int nFail = 0;

  localparam logic [7:0] A_CTRL = 8'h10;
  localparam logic [7:0] A_REL  = 8'h14;
  localparam logic [7:0] A_CUR  = 8'h18;
  localparam logic [7:0] A_CAL  = 8'h1C;

  always #5 clk = ~clk;

  sys_tick_timer u0 (
    .clk(clk), .rst_n(rst_n), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
    .refTick(refTick), .tickIrq(tickIrq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0; busWrData = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busRdEn = 1'b1; busAddr = a;
    #1 d = busRdData;
    @(negedge clk);
    busRdEn = 1'b0;
  endtask

  task automatic tick(output logic irq);
    @(negedge clk);
    refTick = 1'b1;
    @(negedge clk);
    refTick = 1'b0;
    #1 irq = tickIrq;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic        irq;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state, R3 calibration
    rd(A_CTRL, v); chk("R1 ctrl", v, 0);
    rd(A_REL, v);  chk("R1 reload", v, 0);
    rd(A_CUR, v);  chk("R1 cur", v, 0);
    chk("R1 irq", {31'b0, tickIrq}, 0);
    rd(A_CAL, v);  chk("R3 calib", v, 32'd10000);
    wr(A_CAL, 32'h0);
    rd(A_CAL, v);  chk("R3 calib after write", v, 32'd10000);

    // R13 reload width
    wr(A_REL, 32'hFFFF_FFFF);
    rd(A_REL, v);  chk("R13 reload mask", v, 32'h00FF_FFFF);

    // R9 R4 R5 sweep over reload values and interrupt enable, reference ticks
    for (int r = 1; r <= 6; r++) begin
      for (int ie = 0; ie < 2; ie++) begin
        wr(A_REL, r);
        wr(A_CTRL, 32'(1 | (ie << 1)));
        rd(A_CUR, v); chk("R9 load on enable", v, r);
        for (int k = 1; k <= 2 * (r + 1) + 1; k++) begin
          tick(irq);
          chk("R4 R5 irq on wrap", {31'b0, irq},
              ((ie == 1) && (k % (r + 1) == 0)) ? 32'd1 : 32'd0);
          rd(A_CUR, v);
          chk("R9 count", v, 32'(r - (k % (r + 1))));
        end
        rd(A_CTRL, v); chk("R8 flag read", v, 32'(1 | (ie << 1) | (1 << 16)));
        rd(A_CTRL, v); chk("R8 flag cleared", v, 32'(1 | (ie << 1)));
        wr(A_CTRL, 0);
        rd(A_CUR, v); chk("R10 cur reads zero", v, 0);
      end
    end

    // R2 writable bits and flag preservation
    wr(A_REL, 1000);
    wr(A_CTRL, 32'hFFFF_FFFF);
    rd(A_CTRL, v); chk("R2 only low bits", v, 32'h7);
    wr(A_CTRL, 32'hFFFF_FFF8);
    rd(A_CTRL, v); chk("R2 low bits cleared", v, 32'h0);
    wr(A_REL, 1);
    wr(A_CTRL, 1);
    tick(irq); tick(irq);
    wr(A_CTRL, 32'h0001_0000);
    rd(A_CTRL, v); chk("R2 flag kept on write", v, 32'h0001_0000);
    rd(A_CTRL, v); chk("R8 flag cleared by read", v, 32'h0);

    // R6 one-shot with reload zero
    wr(A_REL, 0);
    wr(A_CTRL, 3);
    rd(A_CUR, v); chk("R6 cur zero", v, 0);
    tick(irq); chk("R6 irq", {31'b0, irq}, 1);
    rd(A_CTRL, v); chk("R6 enable cleared", v, 32'h0001_0002);
    tick(irq); chk("R6 stopped", {31'b0, irq}, 0);

    // R10 ticks ignored when disabled
    wr(A_REL, 5);
    wr(A_CTRL, 2);
    for (int i = 0; i < 8; i++) begin
      tick(irq); chk("R10 no irq", {31'b0, irq}, 0);
    end
    rd(A_CUR, v); chk("R10 cur zero", v, 0);
    rd(A_CTRL, v); chk("R10 no flag", v, 32'h2);
    wr(A_CTRL, 3);
    rd(A_CUR, v); chk("R9 fresh load", v, 5);
    wr(A_CTRL, 0);

    // R7 write to current value restarts and clears flag
    wr(A_REL, 7);
    wr(A_CTRL, 1);
    for (int i = 0; i < 8; i++) tick(irq);
    for (int i = 0; i < 3; i++) tick(irq);
    rd(A_CUR, v); chk("R7 before restart", v, 4);
    wr(A_CUR, 32'h1234);
    rd(A_CUR, v); chk("R7 restart", v, 7);
    rd(A_CTRL, v); chk("R7 flag cleared", v, 32'h1);
    wr(A_CTRL, 0);

    // R11 core-clock source: irq every reload+1 cycles
    wr(A_REL, 4);
    wr(A_CTRL, 7);
    for (int n = 1; n <= 12; n++) begin
      @(negedge clk);
      #1 chk("R11 R5 core clock period", {31'b0, tickIrq}, (n % 5 == 0) ? 32'd1 : 32'd0);
    end

    // R12 source change while enabled reloads; R11 reference mode ticks
    wr(A_REL, 50);
    wr(A_CTRL, 5);
    repeat (7) @(negedge clk);
    wr(A_CTRL, 1);
    rd(A_CUR, v); chk("R12 reload on source change", v, 50);
    tick(irq);
    rd(A_CUR, v); chk("R11 reference tick", v, 49);
    wr(A_CTRL, 0);

    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule